// File: doc/BRIEF.md
# Mode-banked processor register file

This block holds the general-purpose registers of a 32-bit processor core. Software sees sixteen logical registers, numbered 0 to 15, but the physical storage behind some of those numbers depends on the current processor mode. This lets an exception handler use its own stack pointer and link register, or a larger private set of registers for fast interrupts, without saving the interrupted code's values first. Logical register 15 is the program counter. It is held outside this block, so the block has no storage for it.

The core drives a 5-bit mode code every cycle. It reads two operands through asynchronous ports addressed by 4-bit logical indices and writes one result at the clock edge. A separate debug port reads any physical slot by its flat index, whatever the current mode. An unrecognised mode code is treated like User mode, and a flag is raised for as long as the code is present. Checking whether a mode change is legal, and sequencing the exceptions that change the mode, are done by other blocks.

The physical slots use a fixed flat numbering. Slots 0–7 hold the shared low registers. Slots 8–14 hold the user bank for logical 8–14. Slot 15 is the hypervisor stack pointer. Slots 16–23 are pairs for the IRQ, Supervisor, Abort and Undefined modes: the even slot of each pair holds logical 14 and the odd slot holds logical 13. Slots 24–30 are the fast-interrupt copies of logical 8–14. Slots 31 and 32 are the Monitor pair.

Top module: `banked_regfile`

## Requirements
- R1: Logical registers 0 to 7 read and write physical slots 0 to 7 in every mode, including unrecognised codes.
- R2: In User mode (10000) and System mode (11111), logical 8 to 14 map to slots 8 to 14.
- R3: In fast-interrupt mode (10001), logical 8 to 14 map to slots 24 to 30 in order, so that logical n uses slot n+16.
- R4: In IRQ (10010), Supervisor (10011), Abort (10111) and Undefined (11011) modes, logical 14 maps to slot 16, 18, 20 or 22 respectively, and logical 13 maps to the next slot up (17, 19, 21 or 23). Logical 8 to 12 use slots 8 to 12.
- R5: In Hypervisor mode (11010), logical 13 maps to slot 15, and logical 8 to 12 and 14 use slots 8 to 12 and 14.
- R6: In Monitor mode (10110), logical 14 maps to slot 31 and logical 13 maps to slot 32. Logical 8 to 12 use slots 8 to 12.
- R7: Any mode code not listed in R2 to R6 maps like User mode, and the error output is high in exactly those cycles. For a listed code the error output is low.
- R8: A write is committed at the rising clock edge to the slot selected by the mode and index present in that cycle. Until that edge, a read of the same register returns the old value.
- R9: Logical index 15 reads as zero on both read ports, and a write to logical index 15 changes no slot.
- R10: The debug port returns the contents of slot 0 to 31, selected by its 5-bit flat index, combinationally and independently of the mode. Slot 32 is reachable only through Monitor-mode logical reads.
- R11: Reset, active low, clears every physical slot to zero.
- R12: The two read ports resolve their indices independently, so they can return different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low reset, clears all slots |
| mode | input | 5 | Current processor mode code |
| rdIdxA | input | 4 | Logical index for read port A |
| rdDataA | output | 32 | Read data A, asynchronous |
| rdIdxB | input | 4 | Logical index for read port B |
| rdDataB | output | 32 | Read data B, asynchronous |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 4 | Logical index to write |
| wrData | input | 32 | Data to write |
| dbgIdx | input | 5 | Flat physical slot index for the debug port |
| dbgData | output | 32 | Contents of the selected slot |
| modeErr | output | 1 | High while the mode code is unrecognised |

## Verification
A wrong mode-to-slot mapping is silent when the write happens. It shows up only when another mode reads the corrupted slot, or when the debug port looks at it, so every write is followed in the same test by debug reads of all reachable slots and by reads of the same logical index from every mode. A write to the wrong slot, a lost write, or a write that goes through on index 15 shows on the debug port one cycle after the edge. Mapping errors on the read side show in the same cycle, because the read path has no register.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

  localparam int NUM_SLOTS = 33;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  typedef enum logic [2:0] {
    MC_USR, MC_FIQ, MC_IRQ, MC_SVC, MC_ABT, MC_UND, MC_MON, MC_HYP
  } modeClassT;

  // strobes from control to datapath
  typedef struct packed {
    logic [SLOT_W-1:0] slotA;
    logic [SLOT_W-1:0] slotB;
    logic [SLOT_W-1:0] slotW;
    logic              rdEnA;
    logic              rdEnB;
    logic              wrStb;
  } bankCtrlT;

  function automatic modeClassT decodeMode(input logic [4:0] m, output logic unknown);
    unknown = 1'b0;
    case (m)
      5'b10000, 5'b11111: decodeMode = MC_USR;
      5'b10001: decodeMode = MC_FIQ;
      5'b10010: decodeMode = MC_IRQ;
      5'b10011: decodeMode = MC_SVC;
      5'b10110: decodeMode = MC_MON;
      5'b10111: decodeMode = MC_ABT;
      5'b11010: decodeMode = MC_HYP;
      5'b11011: decodeMode = MC_UND;
      default: begin
        decodeMode = MC_USR;
        unknown    = 1'b1;
      end
    endcase
  endfunction

  // base slot of a two-register private pair: R14 at base, R13 at base+1
  function automatic logic [SLOT_W-1:0] pairBase(input modeClassT mc);
    case (mc)
      MC_IRQ:  pairBase = SLOT_W'(16);
      MC_SVC:  pairBase = SLOT_W'(18);
      MC_ABT:  pairBase = SLOT_W'(20);
      MC_UND:  pairBase = SLOT_W'(22);
      default: pairBase = SLOT_W'(31);
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] mapSlot(input modeClassT mc, input logic [3:0] idx);
    logic [SLOT_W-1:0] flat;
    flat = SLOT_W'(idx);
    mapSlot = flat;
    if (idx >= 4'd8 && idx <= 4'd14) begin
      case (mc)
        MC_FIQ: mapSlot = flat + SLOT_W'(16);
        MC_HYP: if (idx == 4'd13) mapSlot = SLOT_W'(15);
        MC_IRQ, MC_SVC, MC_ABT, MC_UND, MC_MON: begin
          if (idx == 4'd14)      mapSlot = pairBase(mc);
          else if (idx == 4'd13) mapSlot = pairBase(mc) + SLOT_W'(1);
        end
        default: mapSlot = flat;
      endcase
    end
  endfunction

endpackage

// File: rtl/banked_regfile_ctrl.sv
module banked_regfile_ctrl
  import banked_regfile_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] mode,
  input  logic [3:0] rdIdxA,
  input  logic [3:0] rdIdxB,
  input  logic       wrEn,
  input  logic [3:0] wrIdx,
  output bankCtrlT   ctrl,
  output logic       modeErr
);

  localparam logic [3:0] PC_IDX = 4'd15;

  modeClassT modeClass;
  logic      unknownMode;

  always_comb begin
    modeClass  = decodeMode(mode, unknownMode);
    modeErr    = unknownMode;
    ctrl.slotA = mapSlot(modeClass, rdIdxA);
    ctrl.slotB = mapSlot(modeClass, rdIdxB);
    ctrl.slotW = mapSlot(modeClass, wrIdx);
    ctrl.rdEnA = (rdIdxA != PC_IDX);
    ctrl.rdEnB = (rdIdxB != PC_IDX);
    ctrl.wrStb = wrEn && (wrIdx != PC_IDX);
  end

  a_r1_low_shared: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdxA < 4'd8) |-> (ctrl.slotA == SLOT_W'(rdIdxA)));

  a_r3_fiq_bank: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 5'b10001 && rdIdxB >= 4'd8 && rdIdxB <= 4'd14) |-> (ctrl.slotB >= SLOT_W'(24)));

  a_r7_unknown_as_user: assert property (@(posedge clk) disable iff (!rstN)
    (modeErr && rdIdxA != 4'd15) |-> (ctrl.slotA == SLOT_W'(rdIdxA)));

  a_r9_pc_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (wrIdx == 4'd15) |-> !ctrl.wrStb);

  a_r5_hyp_lr_shared: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 5'b11010 && wrIdx == 4'd14) |-> (ctrl.slotW == SLOT_W'(14)));

endmodule

// File: rtl/banked_regfile_dp.sv
module banked_regfile_dp
  import banked_regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DBG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankCtrlT          ctrl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DBG_W-1:0]  dbgIdx,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] dbgData
);

  logic [DATA_W-1:0] slots [NUM_SLOTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) slots[i] <= '0;
    end else if (ctrl.wrStb) begin
      slots[ctrl.slotW] <= wrData;
    end
  end

  always_comb begin
    rdDataA = ctrl.rdEnA ? slots[ctrl.slotA] : '0;
    rdDataB = ctrl.rdEnB ? slots[ctrl.slotB] : '0;
    dbgData = slots[SLOT_W'(dbgIdx)];
  end

  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrStb |=> (slots[$past(ctrl.slotW)] == $past(wrData)));

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.wrStb && ctrl.slotA == SLOT_W'(5) && ctrl.rdEnA) |=> (slots[5] == $past(rdDataA)));

  a_r10_dbg_vs_read: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.rdEnA && SLOT_W'(dbgIdx) == ctrl.slotA) |-> (dbgData == rdDataA));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_regfile_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        mode,
  input  logic [3:0]        rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [4:0]        dbgIdx,
  output logic [DATA_W-1:0] dbgData,
  output logic              modeErr
);

  bankCtrlT ctrl;

  banked_regfile_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB),
    .wrEn(wrEn), .wrIdx(wrIdx), .ctrl(ctrl), .modeErr(modeErr)
  );

  banked_regfile_dp #(.DATA_W(DATA_W), .DBG_W(5)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(wrData), .dbgIdx(dbgIdx),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .dbgData(dbgData)
  );

endmodule

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
module tb_banked_regfile;

  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_MON = 5'b10110, M_ABT = 5'b10111,
                         M_HYP = 5'b11010, M_UND = 5'b11011, M_SYS = 5'b11111,
                         M_BAD = 5'b00000;

  logic        clk = 0;
  logic        rstN = 0;
  logic [4:0]  mode = M_USR;
  logic [3:0]  rdIdxA = 0, rdIdxB = 0, wrIdx = 0;
  logic [31:0] rdDataA, rdDataB, wrData = 0, dbgData;
  logic        wrEn = 0;
  logic [4:0]  dbgIdx = 0;
  logic        modeErr;

  int total = 0;
  int bad = 0;
  logic [31:0] model [33];

  always #5 clk = ~clk;

  banked_regfile dut (
    .clk(clk), .rstN(rstN), .mode(mode), .rdIdxA(rdIdxA), .rdDataA(rdDataA),
    .rdIdxB(rdIdxB), .rdDataB(rdDataB), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .dbgIdx(dbgIdx), .dbgData(dbgData), .modeErr(modeErr)
  );

  // expected slot from the requirement table (R1..R7); -1 for logical 15
  function automatic int expSlot(input logic [4:0] m, input int idx);
    if (idx == 15) return -1;
    if (idx < 8) return idx;
    case (m)
      M_FIQ: return idx + 16;
      M_IRQ: return (idx == 14) ? 16 : (idx == 13) ? 17 : idx;
      M_SVC: return (idx == 14) ? 18 : (idx == 13) ? 19 : idx;
      M_ABT: return (idx == 14) ? 20 : (idx == 13) ? 21 : idx;
      M_UND: return (idx == 14) ? 22 : (idx == 13) ? 23 : idx;
      M_MON: return (idx == 14) ? 31 : (idx == 13) ? 32 : idx;
      M_HYP: return (idx == 13) ? 15 : idx;
      default: return idx;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [4:0] m, input int idx, input logic [31:0] d);
    int s;
    @(negedge clk);
    mode = m; wrIdx = 4'(idx); wrData = d; wrEn = 1;
    @(negedge clk);
    wrEn = 0;
    s = expSlot(m, idx);
    if (s >= 0) model[s] = d;
  endtask

  task automatic checkDebugAll(input string req);
    for (int s = 0; s < 32; s++) begin
      dbgIdx = 5'(s);
      #1;
      check(req, dbgData, model[s]);
    end
  endtask

  task automatic checkReadsIn(input logic [4:0] m, input string req);
    mode = m;
    for (int i = 0; i < 16; i++) begin
      int sa, sb;
      rdIdxA = 4'(i);
      rdIdxB = 4'(15 - i);
      #1;
      sa = expSlot(m, i);
      sb = expSlot(m, 15 - i);
      check(req, rdDataA, (sa < 0) ? 32'h0 : model[sa]);
      check({req, " portB R12"}, rdDataB, (sb < 0) ? 32'h0 : model[sb]);
    end
  endtask

  task automatic t_reset;
    for (int s = 0; s < 33; s++) model[s] = 32'h0;
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    mode = M_USR; #1;
    check("R7 modeErr low for user", {31'b0, modeErr}, 32'h0);
    checkDebugAll("R11 reset clears slot");
    checkReadsIn(M_MON, "R11 reset clears monitor slots");
  endtask

  task automatic t_fill;
    for (int i = 0; i < 15; i++) doWrite(M_USR, i, 32'h1000_0000 + i);
    for (int i = 8; i < 15; i++) doWrite(M_FIQ, i, 32'h2000_0000 + i);
    doWrite(M_IRQ, 13, 32'h3000_000d); doWrite(M_IRQ, 14, 32'h3000_000e);
    doWrite(M_SVC, 13, 32'h4000_000d); doWrite(M_SVC, 14, 32'h4000_000e);
    doWrite(M_ABT, 13, 32'h5000_000d); doWrite(M_ABT, 14, 32'h5000_000e);
    doWrite(M_UND, 13, 32'h6000_000d); doWrite(M_UND, 14, 32'h6000_000e);
    doWrite(M_HYP, 13, 32'h7000_000d);
    doWrite(M_MON, 13, 32'h8000_000d); doWrite(M_MON, 14, 32'h8000_000e);
    doWrite(M_SVC, 3, 32'h4000_0003);
    doWrite(M_FIQ, 9, 32'h2222_0009);
    checkDebugAll("R10 debug slot after banked writes");
  endtask

  task automatic t_reads;
    checkReadsIn(M_USR, "R2 user map");
    checkReadsIn(M_SYS, "R2 system map");
    checkReadsIn(M_FIQ, "R3 fiq map");
    checkReadsIn(M_IRQ, "R4 irq map");
    checkReadsIn(M_SVC, "R4 svc map");
    checkReadsIn(M_ABT, "R4 abort map");
    checkReadsIn(M_UND, "R4 undef map");
    checkReadsIn(M_HYP, "R5 hyp map");
    checkReadsIn(M_MON, "R6 monitor map");
    mode = M_IRQ; rdIdxA = 4'd2; #1;
    check("R1 shared low reg", rdDataA, model[2]);
  endtask

  task automatic t_rdw;
    @(negedge clk);
    mode = M_SVC; rdIdxA = 4'd13; wrIdx = 4'd13; wrData = 32'hcafe_0013; wrEn = 1;
    #1;
    check("R8 old value before edge", rdDataA, 32'h4000_000d);
    @(posedge clk);
    #1;
    wrEn = 0;
    mode = M_SVC; #1;
    check("R8 new value after edge", rdDataA, 32'hcafe_0013);
    model[19] = 32'hcafe_0013;
    doWrite(M_UND, 14, 32'hbeef_0014);
    mode = M_SVC; rdIdxA = 4'd14; #1;
    check("R8 write used mode of its cycle", rdDataA, 32'h4000_000e);
    checkDebugAll("R8 write slot");
  endtask

  task automatic t_pc;
    doWrite(M_USR, 15, 32'hdead_beef);
    doWrite(M_FIQ, 15, 32'hdead_0001);
    checkDebugAll("R9 pc write changes nothing");
    mode = M_USR; rdIdxA = 4'd15; rdIdxB = 4'd15; #1;
    check("R9 pc read A zero", rdDataA, 32'h0);
    check("R9 pc read B zero", rdDataB, 32'h0);
  endtask

  task automatic t_badmode;
    mode = M_BAD; #1;
    check("R7 modeErr high for unknown", {31'b0, modeErr}, 32'h1);
    checkReadsIn(M_BAD, "R7 unknown maps like user");
    doWrite(5'b10100, 14, 32'h0bad_0014);
    mode = 5'b10100; #1;
    check("R7 modeErr high 10100", {31'b0, modeErr}, 32'h1);
    checkDebugAll("R7 unknown-mode write to user slot");
    mode = M_HYP; #1;
    check("R7 modeErr low for hyp", {31'b0, modeErr}, 32'h0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_reads();
    t_rdw();
    t_pc();
    t_badmode();
    t_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule